// File: doc/BRIEF.md
# Weak-Row Refresh Request Serializer

This block sits on the memory-device side. During a normal refresh, a weak-row checker finds rows with short retention and offers their bank and row addresses here. Each address goes into a small FIFO. A framer then takes the addresses one at a time and sends each as a packet on a single sideband wire. The memory controller receives these packets and schedules an extra activate for each row. The normal refresh is never lengthened, so the block has no busy output.

A packet starts with a fixed 8-bit start pattern. The bank field follows, then the row field, all sent most significant bit first. Each bit stays on the wire for `DIV` clock cycles. The wire is low whenever no packet is being sent. Consecutive packets are separated by at least `GAP_BITS` bit times of low line.

The address input uses valid/ready. `in_ready` is high whenever the FIFO holds fewer than `DEPTH` entries. An address is accepted on any clock edge where both `in_valid` and `in_ready` are high. The producer is a refresh-time checker that cannot wait. So an address offered while `in_ready` is low is dropped and `overflow` is set. Entries already in the queue are kept.

Top module: `weakrow_sideband_tx`

## Requirements
- R1: While `rst_n` is low and right after its release, `sb_tx` is 0, `in_ready` is 1 and `overflow` is 0.
- R2: A packet is `PKT_W = 8 + BANK_W + ROW_W` bits, sent MSB first. It is the start pattern 8'b1010_0111, then `in_bank`, then `in_row`. Each bit is held on `sb_tx` for exactly `DIV` clock cycles.
- R3: `sb_tx` is 0 whenever no packet is in flight.
- R4: After the last bit of a packet, `sb_tx` stays 0 for at least `GAP_BITS*DIV` cycles before the next start pattern begins.
- R5: `in_ready` is 1 exactly when fewer than `DEPTH` addresses are queued and not yet started. An address is queued on every edge where `in_valid` and `in_ready` are both 1.
- R6: An address offered while `in_ready` is 0 is discarded without changing any queued entry. `overflow` goes to 1 after that edge and stays 1 until reset.
- R7: Addresses are sent in the order they were accepted, one packet per accepted address, including addresses accepted on consecutive cycles.
- R8: When the block is idle and the queue is empty, an address accepted on edge k puts the first start bit (1) on `sb_tx` after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also times sideband bits |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Weak-row address offered |
| in_ready | output | 1 | Queue has room |
| in_bank | input | BANK_W | Bank of the weak row |
| in_row | input | ROW_W | Row address of the weak row |
| sb_tx | output | 1 | Serial sideband line, idles low |
| overflow | output | 1 | Sticky: an address was dropped |

## Verification
A corrupted FIFO pointer or count shows up in one of two ways. Either `in_ready` falls at the wrong occupancy on the next cycle, or a packet carries the wrong or repeated address once it reaches the head, which can be several packet times later. A wrong bit or division counter shifts or stretches a bit on `sb_tx`. The per-clock comparison against a behavioural queue model catches that within `DIV` cycles. A framer that leaves the gap state early shows a start bit inside the required low window right away. A lost sticky flag shows on `overflow` on the cycle after the drop.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_SEND = 2'd1,
    FR_GAP  = 2'd2
  } fr_state_e;
endpackage

// File: rtl/wrs_fifo.sv
module wrs_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
  assert_push_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/wrs_framer.sv
module wrs_framer
  import wrs_pkg::*;
#(
  parameter int              PAY_W    = 18,
  parameter int              HDR_W    = 8,
  parameter logic [HDR_W-1:0] HDR     = 8'b1010_0111,
  parameter int              DIV      = 4,
  parameter int              GAP_BITS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             avail,
  input  logic [PAY_W-1:0] payload,
  output logic             take,
  output logic             tx_o
);
  localparam int PKT_W   = HDR_W + PAY_W;
  localparam int GAP_CYC = GAP_BITS * DIV;
  localparam int DW      = $clog2(DIV + 1);
  localparam int BW      = $clog2(PKT_W + 1);
  localparam int GW      = $clog2(GAP_CYC + 1);

  fr_state_e        st;
  logic [PKT_W-1:0] sh;
  logic [DW-1:0]    dcnt;
  logic [BW-1:0]    bcnt;
  logic [GW-1:0]    gcnt;
  logic             tick, last;

  assign take = (st == FR_IDLE) && avail;
  assign tick = (dcnt == DW'(DIV - 1));
  assign last = (bcnt == BW'(PKT_W - 1));
  assign tx_o = (st == FR_SEND) && sh[PKT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= FR_IDLE;
      sh   <= '0;
      dcnt <= '0;
      bcnt <= '0;
      gcnt <= '0;
    end else begin
      case (st)
        FR_IDLE: if (avail) begin
          sh   <= {HDR, payload};
          dcnt <= '0;
          bcnt <= '0;
          st   <= FR_SEND;
        end
        FR_SEND: if (tick) begin
          dcnt <= '0;
          if (last) begin
            gcnt <= '0;
            st   <= FR_GAP;
          end else begin
            sh   <= sh << 1;
            bcnt <= bcnt + 1'b1;
          end
        end else begin
          dcnt <= dcnt + 1'b1;
        end
        FR_GAP: if (gcnt == GW'(GAP_CYC - 1)) st <= FR_IDLE;
                else gcnt <= gcnt + 1'b1;
        default: st <= FR_IDLE;
      endcase
    end
  end

  assert_header_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (tx_o == HDR[HDR_W-1]));
  assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_SEND && !tick) |=> $stable(tx_o));
  assert_gap_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == FR_SEND && tick && last) |=> (st == FR_GAP && !tx_o));
endmodule

// File: rtl/weakrow_sideband_tx.sv
module weakrow_sideband_tx #(
  parameter int         ROW_W    = 15,
  parameter int         BANK_W   = 3,
  parameter int         DEPTH    = 4,
  parameter int         DIV      = 4,
  parameter int         GAP_BITS = 1,
  parameter logic [7:0] HDR      = 8'b1010_0111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  output logic              sb_tx,
  output logic              overflow
);
  localparam int PAY_W = BANK_W + ROW_W;

  logic             full, empty, take, push;
  logic [PAY_W-1:0] head;

  assign in_ready = !full;
  assign push     = in_valid && !full;

  wrs_fifo #(.W(PAY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata({in_bank, in_row}),
    .pop(take), .rdata(head), .full(full), .empty(empty)
  );

  wrs_framer #(.PAY_W(PAY_W), .HDR_W(8), .HDR(HDR), .DIV(DIV),
               .GAP_BITS(GAP_BITS)) u_framer (
    .clk(clk), .rst_n(rst_n), .avail(!empty), .payload(head),
    .take(take), .tx_o(sb_tx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow <= 1'b0;
    else if (in_valid && full) overflow <= 1'b1;
  end

  assert_drop_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overflow);
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: tb/test_weakrow_sideband_tx.sv
module test_weakrow_sideband_tx;
  localparam int ROW_W = 15, BANK_W = 3, DEPTH = 4, DIV = 4, GAP_BITS = 1;
  localparam int PAY_W = ROW_W + BANK_W;
  localparam int PKT_W = 8 + PAY_W;
  localparam logic [7:0] HDR = 8'b1010_0111;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [BANK_W-1:0] in_bank = '0;
  logic [ROW_W-1:0]  in_row = '0;
  logic in_ready, sb_tx, overflow;

  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  weakrow_sideband_tx i_weakrow_sideband_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bank(in_bank), .in_row(in_row), .sb_tx(sb_tx), .overflow(overflow)
  );

  // behavioural reference: queue plus packet timers
  logic [PAY_W-1:0] q[$];
  int m_st = 0, m_d = 0, m_b = 0, m_g = 0;
  logic [PKT_W-1:0] m_pkt = '0;
  bit m_ovf = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete(); m_st = 0; m_d = 0; m_b = 0; m_g = 0; m_ovf = 0;
    end else begin
      bit room;
      room = (q.size() < DEPTH);
      case (m_st)
        0: if (q.size() > 0) begin
             m_pkt = {HDR, q.pop_front()}; m_d = 0; m_b = 0; m_st = 1;
           end
        1: if (m_d == DIV - 1) begin
             m_d = 0;
             if (m_b == PKT_W - 1) begin m_g = 0; m_st = 2; end
             else m_b++;
           end else m_d++;
        default: if (m_g == GAP_BITS * DIV - 1) m_st = 0; else m_g++;
      endcase
      if (in_valid) begin
        if (room) q.push_back({in_bank, in_row});
        else m_ovf = 1;
      end
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b time=%0t", req, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic exp_tx;
      exp_tx = (m_st == 1) ? m_pkt[PKT_W-1-m_b] : 1'b0;
      case (m_st)
        1:       check("R2 R7 line", sb_tx, exp_tx);
        2:       check("R4 gap", sb_tx, exp_tx);
        default: check("R3 idle", sb_tx, exp_tx);
      endcase
      check("R5 ready", in_ready, q.size() < DEPTH);
      check("R6 overflow", overflow, m_ovf);
    end
  end

  task automatic offer(input logic [BANK_W-1:0] b, input logic [ROW_W-1:0] r);
    @(negedge clk);
    in_valid = 1; in_bank = b; in_row = r;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic burst(input int n, input int seed);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      in_valid = 1;
      in_bank  = BANK_W'(seed + i);
      in_row   = ROW_W'((seed * 977 + i * 4099) ^ 15'h2aa5);
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic drain();
    while (q.size() > 0 || m_st != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: values held in reset
    check("R1 tx", sb_tx, 1'b0);
    check("R1 ready", in_ready, 1'b1);
    check("R1 ovf", overflow, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check("R1 tx after release", sb_tx, 1'b0);

    // R8: start latency from idle and empty
    @(negedge clk);
    in_valid = 1; in_bank = 3'd5; in_row = 15'h1234;
    @(negedge clk);           // edge k accepted
    in_valid = 0;
    check("R8 not yet", sb_tx, 1'b0);
    @(negedge clk);           // edge k+1 loaded
    check("R8 start bit", sb_tx, 1'b1);
    drain();

    // boundary patterns for R2
    offer('1, '1);
    drain();
    offer('0, '0);
    drain();

    // R7: two rows found in the same refresh, consecutive cycles
    burst(2, 11);
    drain();

    // R5 R6: fill past depth; extra offers dropped, flag sticks
    burst(DEPTH + 3, 40);
    check("R6 flag raised", overflow, 1'b1);
    drain();
    check("R6 flag sticky", overflow, 1'b1);

    // R4: a steady stream keeps the gap
    burst(3, 77);
    offer(3'd2, 15'h5555);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule